// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a single-level data cache placed between a processor load/store port and a main-memory port. Every byte address picks exactly one cache line. A line is four 32-bit words that share one valid flag and one tag. A read that finds its line returns the selected word in the same cycle. A read or write that misses stalls the processor while the whole four-word line is fetched from memory. The processor keeps its request asserted while stalled. Once the refill ends, the retried access hits.

Writes are write-through with write-allocate. The word is put into the indexed line while the tag compare runs. On a miss, the line is first refilled from memory. The retry then merges the new word into the fresh line. Each write sends exactly one word write to main memory, in the cycle the write completes.

Top module: `dm_wt_cache`

## Requirements
- R1: A hit needs two things: the line's valid flag is set, and its stored tag equals address bits 31..16. The line is chosen by address bits 15..4. An access to a valid line that holds a different tag is a miss.
- R2: After reset no line is valid, so the first access to any line misses. With no request pending, `cpu_stall`, `mem_rd_req` and `mem_wr_en` are all low.
- R3: A read hit has `cpu_hit` high and `cpu_stall` low in the same cycle. `cpu_rdata` is the line word chosen by address bits 3..2 (0 selects the lowest word).
- R4: On a miss, `cpu_stall` rises in the cycle the miss is seen and stays high until the refill ends. During the refill, `mem_rd_req` is held high and `mem_addr` is held at the line address, which is the request address with bits 3..0 cleared.
- R5: Refill words are taken one per cycle in which `mem_rd_valid` is high, in order from word 0 to word 3. The tag and valid flag are set only after word 3. In the next cycle the held request hits and sees the fetched data.
- R6: A write hit stores the word in the line. In the same cycle it pulses `mem_wr_en` with `mem_wr_addr` equal to the request address with bits 1..0 cleared and `mem_wr_data` equal to `cpu_wdata`.
- R7: A write miss refills the whole line first. It then merges the new word and sends it to memory, once, in the hit cycle after the refill.
- R8: Reads never pulse `mem_wr_en`. A write pulses it exactly once.
- R9: `mem_rd_valid` and `mem_rd_data` have no effect on the cache while no refill is in progress.
- R10: Address bits 1..0 do not affect hit, word select or stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word of the addressed line |
| cpu_hit | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_rd_req | output | 1 | Line refill in progress |
| mem_addr | output | 32 | Line-aligned refill address |
| mem_rd_valid | input | 1 | Refill word present this cycle |
| mem_rd_data | input | 32 | Refill word |
| mem_wr_en | output | 1 | Write-through word write |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write-through data |

## Verification
The properties assume that the processor keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` unchanged from the first stalled cycle until the hit. This is why a refill that ends must be followed by a hit, and why the refill address may not move. The bench drives each access from one task that holds those inputs until it sees `cpu_hit`. It raises `mem_rd_valid` at random during refills, and also while the cache is idle, with junk data. The bench's own model of tags and memory predicts hit, miss, read data and write-through traffic.

// File: rtl/dm_wt_cache_pkg.sv
package dm_wt_cache_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_state_e;

  localparam int unsigned BYTE_SEL_W = 2;
endpackage

// File: rtl/dm_wt_cache_tags.sv
module dm_wt_cache_tags #(
  parameter int unsigned LINES = 4096,
  parameter int unsigned TAG_W = 16,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  output logic             line_vld,
  output logic [TAG_W-1:0] line_tag
);
  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] vld_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    vld_d = vld_q;
    if (set_en) vld_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[idx] <= set_tag;
  end

  assign line_vld = vld_q[idx];
  assign line_tag = tag_q[idx];
endmodule

// File: rtl/dm_wt_cache_data.sv
module dm_wt_cache_data #(
  parameter int unsigned LINES  = 4096,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic                         clk,
  input  logic [IDX_W-1:0]             idx,
  input  logic [WORDS-1:0]             word_we,
  input  logic [DATA_W-1:0]            word_wdata,
  output logic [WORDS-1:0][DATA_W-1:0] line_words
);
  for (genvar b = 0; b < WORDS; b++) begin : g_bank
    logic [DATA_W-1:0] bank_q [LINES];

    always_ff @(posedge clk) begin
      if (word_we[b]) bank_q[idx] <= word_wdata;
    end

    assign line_words[b] = bank_q[idx];
  end
endmodule

// File: rtl/dm_wt_cache_ctrl.sv
module dm_wt_cache_ctrl
  import dm_wt_cache_pkg::*;
#(
  parameter int unsigned WORDS = 4,
  localparam int unsigned WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              miss,
  input  logic              beat_valid,
  output logic              filling,
  output logic [WSEL_W-1:0] beat_idx,
  output logic              beat_last
);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  fill_state_e       st_q, st_d;
  logic [WSEL_W-1:0] cnt_q, cnt_d;

  assign filling   = (st_q == FS_FILL);
  assign beat_idx  = cnt_q;
  assign beat_last = filling && beat_valid && (cnt_q == LAST_BEAT);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      FS_IDLE: begin
        cnt_d = '0;
        if (req && miss) st_d = FS_FILL;
      end
      FS_FILL: begin
        if (beat_valid) cnt_d = cnt_q + 1'b1;
        if (beat_last)  st_d  = FS_IDLE;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
  import dm_wt_cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINES  = 4096,
  parameter int unsigned WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_stall,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned WSEL_W = $clog2(WORDS);
  localparam int unsigned IDX_LO = WSEL_W + BYTE_SEL_W;
  localparam int unsigned TAG_LO = IDX_LO + IDX_W;
  localparam int unsigned TAG_W  = ADDR_W - TAG_LO;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_wsel;
  logic              unused_byte_sel;

  assign a_tag           = cpu_addr[ADDR_W-1:TAG_LO];
  assign a_idx           = cpu_addr[TAG_LO-1:IDX_LO];
  assign a_wsel          = cpu_addr[IDX_LO-1:BYTE_SEL_W];
  assign unused_byte_sel = ^cpu_addr[BYTE_SEL_W-1:0];

  logic              line_vld;
  logic [TAG_W-1:0]  line_tag;
  logic              lookup_miss;
  logic              filling;
  logic [WSEL_W-1:0] beat_idx;
  logic              beat_last;
  logic              idle_access;
  logic [WORDS-1:0]  word_we;
  logic [DATA_W-1:0] word_wdata;
  logic [WORDS-1:0][DATA_W-1:0] line_words;

  assign lookup_miss = !(line_vld && (line_tag == a_tag));
  assign idle_access = cpu_req && !filling;

  dm_wt_cache_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .idx      (a_idx),
    .set_en   (beat_last),
    .set_tag  (a_tag),
    .line_vld (line_vld),
    .line_tag (line_tag)
  );

  dm_wt_cache_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .req        (cpu_req),
    .miss       (lookup_miss),
    .beat_valid (mem_rd_valid),
    .filling    (filling),
    .beat_idx   (beat_idx),
    .beat_last  (beat_last)
  );

  // word store runs alongside the tag compare; a miss overwrites the line on refill
  for (genvar b = 0; b < WORDS; b++) begin : g_we
    assign word_we[b] = (idle_access && cpu_we && (a_wsel == WSEL_W'(b)))
                      || (filling && mem_rd_valid && (beat_idx == WSEL_W'(b)));
  end
  assign word_wdata = filling ? mem_rd_data : cpu_wdata;

  dm_wt_cache_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .idx        (a_idx),
    .word_we    (word_we),
    .word_wdata (word_wdata),
    .line_words (line_words)
  );

  assign cpu_rdata   = line_words[a_wsel];
  assign cpu_hit     = idle_access && !lookup_miss;
  assign cpu_stall   = filling || (cpu_req && lookup_miss);
  assign mem_rd_req  = filling;
  assign mem_addr    = {a_tag, a_idx, {IDX_LO{1'b0}}};
  assign mem_wr_en   = cpu_hit && cpu_we;
  assign mem_wr_addr = {cpu_addr[ADDR_W-1:BYTE_SEL_W], {BYTE_SEL_W{1'b0}}};
  assign mem_wr_data = cpu_wdata;
endmodule

// File: rtl/dm_wt_cache_chk.sv
module dm_wt_cache_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_hit,
  input logic              cpu_stall,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_valid,
  input logic              mem_wr_en
);
  // R4: refill address is line aligned
  p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_addr[3:0] == 4'b0));

  // R4: processor held off for the whole refill
  p_stall_in_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (cpu_stall && !cpu_hit));

  // R4: refill address does not move
  p_fill_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && $past(mem_rd_req)) |-> $stable(mem_addr));

  // R3: a completing access is never stalled
  p_hit_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> !cpu_stall);

  // R5: refill ends on an accepted word and the held request then hits
  p_fill_end_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_req) |-> $past(mem_rd_valid));
  p_fill_then_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_req) |-> cpu_hit);

  // R8: memory write only for a completing write
  p_wr_on_write_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (cpu_req && cpu_we && cpu_hit));

  // R7: no write-through while the line is being refilled
  p_no_wr_in_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !mem_wr_en);
endmodule

bind dm_wt_cache dm_wt_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_hit      (cpu_hit),
  .cpu_stall    (cpu_stall),
  .mem_rd_req   (mem_rd_req),
  .mem_addr     (mem_addr),
  .mem_rd_valid (mem_rd_valid),
  .mem_wr_en    (mem_wr_en)
);

// File: tb/dm_wt_cache_test.sv
module dm_wt_cache_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_hit, cpu_stall;
  logic        mem_rd_req;
  logic [31:0] mem_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        mem_wr_en;
  logic [31:0] mem_wr_addr, mem_wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] wmem [logic [31:0]];
  bit          rvld [int];
  logic [15:0] rtag [int];

  dm_wt_cache uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
    .mem_rd_req(mem_rd_req), .mem_addr(mem_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] word_at(input logic [31:0] wa);
    if (wmem.exists(wa)) return wmem[wa];
    return (wa * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one processor access, held until it completes
  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd);
    int          idx;
    logic [15:0] tg;
    bit          exp_hit;
    int          n;
    bit          v;
    logic [31:0] wa;
    idx = int'(a[15:4]);
    tg  = a[31:16];
    wa  = {a[31:2], 2'b00};
    exp_hit = rvld.exists(idx) && (rtag[idx] == tg);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    mem_rd_valid = ($urandom % 4) == 0;   // R9: stray beat while idle
    mem_rd_data  = $urandom;
    #1;
    chk(cpu_hit == exp_hit, "R1 hit", 32'(cpu_hit), 32'(exp_hit));
    if (!exp_hit) begin
      chk(cpu_stall == 1'b1, "R4 stall on miss", 32'(cpu_stall), 32'd1);
      n = 0;
      @(posedge clk);
      while (n < 4) begin
        @(negedge clk);
        v = ($urandom % 3) != 0;
        mem_rd_valid = v;
        mem_rd_data  = word_at({tg, a[15:4], 2'(n), 2'b00});
        #1;
        chk(mem_rd_req && cpu_stall && !cpu_hit, "R4 refill stall",
            {29'd0, mem_rd_req, cpu_stall, cpu_hit}, 32'd6);
        chk(mem_addr == {a[31:4], 4'b0}, "R4 refill addr", mem_addr, {a[31:4], 4'b0});
        chk(!mem_wr_en, "R7 no write during refill", 32'(mem_wr_en), 32'd0);
        @(posedge clk);
        if (v) n++;
      end
      rvld[idx] = 1'b1;
      rtag[idx] = tg;
      @(negedge clk);
      mem_rd_valid = 1'b0;
      #1;
      chk(cpu_hit && !cpu_stall, "R5 hit after refill", {30'd0, cpu_hit, cpu_stall}, 32'd2);
    end else begin
      chk(!cpu_stall, "R3 no stall on hit", 32'(cpu_stall), 32'd0);
    end
    if (!we) begin
      chk(cpu_rdata == word_at(wa), "R3 read word", cpu_rdata, word_at(wa));
      chk(!mem_wr_en, "R8 no write on read", 32'(mem_wr_en), 32'd0);
    end else begin
      chk(mem_wr_en, exp_hit ? "R6 write-through" : "R7 write-through", 32'(mem_wr_en), 32'd1);
      chk(mem_wr_addr == wa, "R6 write addr", mem_wr_addr, wa);
      chk(mem_wr_data == wd, "R6 write data", mem_wr_data, wd);
      wmem[wa] = wd;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    mem_rd_valid = ($urandom % 2) == 0;   // R9: stray beat with no request
    mem_rd_data  = $urandom;
    #1;
    chk(!mem_wr_en && !mem_rd_req, "R8 quiet when idle", {30'd0, mem_wr_en, mem_rd_req}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    mem_rd_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'd1957));
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mem_rd_valid = 1'b0; mem_rd_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!cpu_stall && !mem_rd_req && !mem_wr_en, "R2 reset outputs",
        {29'd0, cpu_stall, mem_rd_req, mem_wr_en}, 32'd0);

    // directed corner cases
    access(1'b0, 32'd131408, '0);           // R2: first access misses
    access(1'b0, 32'd131408 + 32'd4, '0);   // R3: other word of same line
    access(1'b0, 32'd131408 + 32'd15, '0);  // R10: byte offset 3 of word 3
    access(1'b0, 32'h0003_0150, '0);        // R1: same line, other tag
    access(1'b0, 32'd131408, '0);           // R1: evicted, misses again
    access(1'b1, 32'd131408 + 32'd9, 32'hCAFE_0001);  // R6 write hit, R10
    access(1'b0, 32'd131408 + 32'd8, '0);   // R6 word stored
    access(1'b1, 32'h0007_FFFC, 32'hBEEF_0002);       // R7 write miss, last line
    access(1'b0, 32'h0007_FFF0, '0);        // R7 rest of line refilled
    access(1'b0, 32'h0007_FFFC, '0);        // R7 merged word

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      a = {14'd0, 2'($urandom % 4), 8'd0, 4'($urandom % 8), 4'($urandom)};
      if (($urandom % 10) == 0) a[15:4] = 12'hFFF;
      access(($urandom % 3) == 0, a, $urandom);
    end
    summary();
  end
endmodule